// File: doc/BRIEF.md
# Random Generator Command Controller

This block is the register-mapped front end of a pseudo-random number generator. Software issues commands by writing a control register: do nothing, produce a fresh result, or reload the generator state from a seed. While a command runs, the status register shows which one is busy. A finished result sits in a bank of eight 32-bit result words. Three event causes (result ready, seed loaded, generator lockup) sit behind a write-one-to-clear status register and a masked interrupt line.

The generator is a deterministic 32-bit Galois LFSR. It stands in for a real entropy source, and its reseed value is taken from the `seed_in` input. Reseeding can also start on its own: after a set number of generate commands, or after a set number of clock cycles, or both. Reads have one cycle of latency. `bus_rdata` shows the addressed register on the cycle after `bus_rd` is sampled.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, status (0x04), cause (0x14), every result word (0x20..0x3C) and `irq` read 0.
- R2: Writing 0 to control (0x00) has no effect. Any code other than 1 or 2 also has no effect: no busy bit rises and no cause bit is set.
- R3: Writing 1 makes status bit 30 read 1 for exactly 16 cycles. Writing 2 makes status bit 31 read 1 for exactly 32 cycles. The two bits are never 1 together.
- R4: When a reseed ends, the LFSR state becomes `seed_in`. Status bit 9 (seeded) is then set, and so is cause bit 1.
- R5: A generate steps the LFSR once per cycle. Each step shifts the state left by one and, when the bit shifted out is 1, XORs 0x00400007 into the state. Word k (offset 0x20+4k) receives the state after 2(k+1) steps. All words update together on the final cycle, and cause bit 0 is set at the same time. At no other time do the words change.
- R6: Mode bit 3 (0x08) set gives eight valid words. Clear gives four valid words, with words 4..7 reading 0. Status bit 3 mirrors mode bit 3, and status bit 2 mirrors bit 2 of the secure-mode register (0x0C).
- R7: A control write that arrives while either busy bit is 1 is dropped.
- R8: Writing 1 to cause bit 0, 1 or 4 clears it, and other cause bits are left alone. A cause that is set in the same cycle stays set.
- R9: `irq` is 1 only when enable bit 31 (0x10) is 1 and some cause is pending with its enable set (enables at bits 0, 1 and 4). It follows one cycle after a change.
- R10: If the LFSR state is all zeros, cause bit 4 is set and the state is replaced by 0xACE10001.
- R11: A nonzero value N written to 0x60 starts an automatic reseed after every N generate commands. The reseed begins once the generator is idle. Writing 0 disables this.
- R12: A nonzero value T written to 0x64 starts an automatic reseed every T cycles. Writing 0 disables this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| seed_in | input | 32 | Value loaded into the LFSR when a reseed ends |
| irq | output | 1 | Registered interrupt request |

## Verification
The lockup path is the hardest case to reach. A correctly running LFSR never arrives at zero, so the stimulus reseeds with a zero `seed_in` to force the all-zero state. The bench then checks that cause bit 4 is set and that the next result follows from the replacement constant. Automatic reseeds carry no command of their own. They are therefore detected indirectly, through the seed-done cause and through a following result that starts from the new `seed_in`. The bench also checks that the age timer does not fire early and stays quiet once disabled.

// File: rtl/rng_cmd_pkg.sv
package rng_cmd_pkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_MODE  = 'h08;
  localparam int OFF_SMODE = 'h0C;
  localparam int OFF_IE    = 'h10;
  localparam int OFF_ISTAT = 'h14;
  localparam int OFF_RES0  = 'h20;
  localparam int OFF_AREQ  = 'h60;
  localparam int OFF_AAGE  = 'h64;

  localparam logic [31:0] CMD_NOP  = 32'd0;
  localparam logic [31:0] CMD_GEN  = 32'd1;
  localparam logic [31:0] CMD_SEED = 32'd2;

  localparam int BIT_NONCE  = 2;
  localparam int BIT_W256   = 3;
  localparam int BIT_SEEDED = 9;
  localparam int BIT_GEN    = 30;
  localparam int BIT_SEED   = 31;

  localparam int CS_RDY  = 0;
  localparam int CS_SEED = 1;
  localparam int CS_LOCK = 4;
  localparam int IE_GLB  = 31;
  localparam logic [31:0] IE_MASK = 32'h8000_0013;
endpackage

// File: rtl/rng_lfsr_core.sv
module rng_lfsr_core #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h0040_0007,
  parameter logic [W-1:0] FIX  = 32'hACE1_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state,
  output logic [W-1:0] nxt,
  output logic         zero
);
  assign nxt  = {state[W-2:0], 1'b0} ^ (state[W-1] ? TAPS : '0);
  assign zero = (state == '0);

  always_ff @(posedge clk) begin
    if (rst)       state <= FIX;
    else if (load) state <= load_val;
    else if (zero) state <= FIX;
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/rng_auto_reseed.sv
module rng_auto_reseed #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_wr,
  input  logic          age_wr,
  input  logic [CW-1:0] wval,
  input  logic          gen_accept,
  output logic [CW-1:0] req_reload,
  output logic [CW-1:0] age_reload,
  output logic          fire
);
  logic [CW-1:0] req_cnt, age_cnt;
  logic          req_hit, age_hit;

  assign req_hit = !req_wr && gen_accept && (req_reload != '0) && (req_cnt <= CW'(1));
  assign age_hit = !age_wr && (age_reload != '0) && (age_cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_reload <= '0;
      req_cnt    <= '0;
    end else if (req_wr) begin
      req_reload <= wval;
      req_cnt    <= wval;
    end else if (gen_accept && req_reload != '0) begin
      req_cnt <= req_hit ? req_reload : req_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_reload <= '0;
      age_cnt    <= '0;
    end else if (age_wr) begin
      age_reload <= wval;
      age_cnt    <= wval;
    end else if (age_reload != '0) begin
      age_cnt <= age_hit ? age_reload : age_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fire <= 1'b0;
    else     fire <= req_hit | age_hit;
  end
endmodule

// File: rtl/rng_irq_unit.sv
module rng_irq_unit #(
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] set,
  input  logic [NC-1:0] clr,
  input  logic [NC-1:0] en,
  input  logic          glb,
  output logic [NC-1:0] cause,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      irq   <= 1'b0;
    end else begin
      for (int k = 0; k < NC; k++)
        cause[k] <= set[k] | (cause[k] & ~clr[k]);
      irq <= glb & |(cause & en);
    end
  end
endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rng_cmd_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          CW          = 16,
  parameter int          WORDS       = 8,
  parameter int          GEN_CYCLES  = 16,
  parameter int          SEED_CYCLES = 32,
  parameter logic [31:0] LFSR_TAPS   = 32'h0040_0007,
  parameter logic [31:0] LFSR_FIX    = 32'hACE1_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   seed_in,
  output logic          irq
);
  localparam int IW   = $clog2(WORDS);
  localparam int HALF = WORDS / 2;
  localparam int SPW  = GEN_CYCLES / WORDS;
  localparam int MAXC = (SEED_CYCLES > GEN_CYCLES) ? SEED_CYCLES : GEN_CYCLES;
  localparam int CNTW = $clog2(MAXC);

  logic            gen_busy, seed_busy, seeded_q, w256_q, nonce_q, pend_q;
  logic [31:0]     ie_q;
  logic [CNTW-1:0] cnt_q, step_idx;
  logic [31:0]     lfsr_q, lfsr_nxt;
  logic            lfsr_zero, auto_fire;
  logic [CW-1:0]   areq_q, aage_q;
  logic [2:0]      cause_w;
  logic [WORDS-1:0][31:0] res_all;

  wire idle     = !gen_busy && !seed_busy;
  wire ctrl_wr  = bus_wr && bus_addr == AW'(OFF_CTRL);
  wire istat_wr = bus_wr && bus_addr == AW'(OFF_ISTAT);
  wire start_seed = idle && (pend_q || auto_fire || (ctrl_wr && bus_wdata == CMD_SEED));
  wire start_gen  = idle && !pend_q && !auto_fire && ctrl_wr && bus_wdata == CMD_GEN;
  wire gen_last   = gen_busy && cnt_q == '0;
  wire seed_last  = seed_busy && cnt_q == '0;

  assign step_idx = CNTW'(GEN_CYCLES - 1) - cnt_q;

  // command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_busy  <= 1'b0;
      seed_busy <= 1'b0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      seeded_q  <= 1'b0;
    end else begin
      if (start_seed) begin
        seed_busy <= 1'b1;
        cnt_q     <= CNTW'(SEED_CYCLES - 1);
      end else if (start_gen) begin
        gen_busy <= 1'b1;
        cnt_q    <= CNTW'(GEN_CYCLES - 1);
      end else if (!idle) begin
        if (cnt_q == '0) begin
          gen_busy  <= 1'b0;
          seed_busy <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNTW'(1);
        end
      end
      if (start_seed)     pend_q <= 1'b0;
      else if (auto_fire) pend_q <= 1'b1;
      if (seed_last) seeded_q <= 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      w256_q  <= 1'b0;
      nonce_q <= 1'b0;
      ie_q    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(OFF_MODE))  w256_q  <= bus_wdata[BIT_W256];
      if (bus_addr == AW'(OFF_SMODE)) nonce_q <= bus_wdata[BIT_NONCE];
      if (bus_addr == AW'(OFF_IE))    ie_q    <= bus_wdata & IE_MASK;
    end
  end

  // result capture: shadow words during generation, bank copy at the end
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [31:0] res_w, fin_w;
    if (k < WORDS - 1) begin : g_shadow
      logic [31:0] sh_w;
      always_ff @(posedge clk) begin
        if (gen_busy && step_idx == CNTW'(SPW * (k + 1) - 1)) sh_w <= lfsr_nxt;
      end
      assign fin_w = sh_w;
    end else begin : g_tail
      assign fin_w = lfsr_nxt;
    end
    always_ff @(posedge clk) begin
      if (rst)           res_w <= '0;
      else if (gen_last) res_w <= (!w256_q && k >= HALF) ? '0 : fin_w;
    end
    assign res_all[k] = res_w;
  end

  rng_lfsr_core #(.W(32), .TAPS(LFSR_TAPS), .FIX(LFSR_FIX)) u_lfsr (
    .clk(clk), .rst(rst), .step(gen_busy), .load(seed_last), .load_val(seed_in),
    .state(lfsr_q), .nxt(lfsr_nxt), .zero(lfsr_zero)
  );

  rng_auto_reseed #(.CW(CW)) u_auto (
    .clk(clk), .rst(rst),
    .req_wr(bus_wr && bus_addr == AW'(OFF_AREQ)),
    .age_wr(bus_wr && bus_addr == AW'(OFF_AAGE)),
    .wval(bus_wdata[CW-1:0]), .gen_accept(start_gen),
    .req_reload(areq_q), .age_reload(aage_q), .fire(auto_fire)
  );

  rng_irq_unit #(.NC(3)) u_irq (
    .clk(clk), .rst(rst),
    .set({lfsr_zero, seed_last, gen_last}),
    .clr({3{istat_wr}} & {bus_wdata[CS_LOCK], bus_wdata[CS_SEED], bus_wdata[CS_RDY]}),
    .en({ie_q[CS_LOCK], ie_q[CS_SEED], ie_q[CS_RDY]}),
    .glb(ie_q[IE_GLB]), .cause(cause_w), .irq(irq)
  );

  // registered read port
  logic [31:0] rd_word;
  wire in_res = bus_addr >= AW'(OFF_RES0) && bus_addr < AW'(OFF_RES0 + 4 * WORDS);
  wire [IW-1:0] res_idx = IW'((bus_addr - AW'(OFF_RES0)) >> 2);

  always_comb begin
    rd_word = '0;
    if (in_res) rd_word = res_all[res_idx];
    else begin
      case (bus_addr)
        AW'(OFF_STAT): begin
          rd_word[BIT_SEED]   = seed_busy;
          rd_word[BIT_GEN]    = gen_busy;
          rd_word[BIT_SEEDED] = seeded_q;
          rd_word[BIT_W256]   = w256_q;
          rd_word[BIT_NONCE]  = nonce_q;
        end
        AW'(OFF_MODE):  rd_word[BIT_W256]  = w256_q;
        AW'(OFF_SMODE): rd_word[BIT_NONCE] = nonce_q;
        AW'(OFF_IE):    rd_word = ie_q;
        AW'(OFF_ISTAT): begin
          rd_word[CS_RDY]  = cause_w[0];
          rd_word[CS_SEED] = cause_w[1];
          rd_word[CS_LOCK] = cause_w[2];
        end
        AW'(OFF_AREQ):  rd_word = 32'(areq_q);
        AW'(OFF_AAGE):  rd_word = 32'(aage_q);
        default:        rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/rng_cmd_ctrl_chk.sv
module rng_cmd_ctrl_chk
  import rng_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          gen_busy,
  input logic          seed_busy,
  input logic          irq,
  input logic          ie_glb,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          wd0,
  input logic          rdy_set,
  input logic          istat0,
  input logic          istat4,
  input logic [31:0]   lfsr,
  input logic [31:0]   res0
);
  p_busy_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(gen_busy && seed_busy));

  p_seed_from_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(seed_busy) |-> $past(!gen_busy));

  p_gen_from_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(gen_busy) |-> $past(!seed_busy));

  p_res_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rdy_set |=> $stable(res0));

  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFF_ISTAT) && wd0 && !rdy_set) |=> !istat0);

  p_irq_glb_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_glb));

  p_lock_fix_r10: assert property (@(posedge clk) disable iff (rst)
    (lfsr == '0) |=> (istat4 && lfsr != '0));
endmodule

bind rng_cmd_ctrl rng_cmd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .gen_busy(gen_busy), .seed_busy(seed_busy), .irq(irq),
  .ie_glb(ie_q[31]), .bus_wr(bus_wr), .bus_addr(bus_addr), .wd0(bus_wdata[0]),
  .rdy_set(gen_last), .istat0(cause_w[0]), .istat4(cause_w[2]),
  .lfsr(lfsr_q), .res0(res_all[0])
);

// File: tb/sim_rng_cmd_ctrl.sv
module sim_rng_cmd_ctrl;
  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, seed_in = '0, bus_rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  logic [31:0] m = 32'hACE1_0001;
  bit w256 = 1'b0;

  always #4 clk = ~clk;

  rng_cmd_ctrl u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seed_in(seed_in), .irq(irq));

  function automatic logic [31:0] nx(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic reseed(input logic [31:0] s);
    seed_in = s;
    wr(8'h00, 32'd2);
    idle(40);
    m = (s == 32'h0) ? 32'hACE1_0001 : s;
  endtask

  task automatic gen_check(input string tag);
    logic [31:0] s, d;
    wr(8'h00, 32'd1);
    idle(20);
    s = m;
    for (int k = 0; k < 8; k++) begin
      s = nx(nx(s));
      rd(8'(8'h20 + 4 * k), d);
      chk(tag, d, (w256 || k < 4) ? s : 32'h0);
    end
    m = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240));
    idle(5); rst = 1'b0; idle(2);

    // R1 reset values
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h14, d); chk("R1 cause", d, 0);
    rd(8'h20, d); chk("R1 word0", d, 0);
    rd(8'h3C, d); chk("R1 word7", d, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R2 no-op and unknown codes
    wr(8'h00, 32'd0); rd(8'h04, d); chk("R2 nop status", d, 0);
    wr(8'h00, 32'd3); rd(8'h04, d); chk("R2 code3 status", d, 0);
    wr(8'h00, 32'h55); idle(20); rd(8'h14, d); chk("R2 code55 cause", d, 0);

    // R3 reseed busy window, R4 seeded and seed-done
    seed_in = 32'h1234_5678;
    wr(8'h00, 32'd2); idle(31);
    rd(8'h04, d); chk("R3 seed busy at 32", {31'h0, d[31]}, 1);
    rd(8'h04, d); chk("R3 seed idle at 33", {31'h0, d[31]}, 0);
    chk("R4 seeded bit", {31'h0, d[9]}, 1);
    rd(8'h14, d); chk("R4 seed done cause", d, 32'h2);
    m = 32'h1234_5678;

    // R3 generate busy window, R5 words in 128-bit mode (R6)
    wr(8'h00, 32'd1); idle(15);
    rd(8'h04, d); chk("R3 gen busy at 16", {30'h0, d[31:30]}, 32'h1);
    rd(8'h04, d); chk("R3 gen idle at 17", {30'h0, d[31:30]}, 0);
    begin
      logic [31:0] s; s = m;
      for (int k = 0; k < 8; k++) begin
        s = nx(nx(s));
        rd(8'(8'h20 + 4 * k), d);
        chk("R5 R6 word 128-bit", d, (k < 4) ? s : 32'h0);
      end
      m = s;
    end
    rd(8'h14, d); chk("R5 ready cause", d, 32'h3);

    // R6 mode and nonce mirrors, 256-bit result
    wr(8'h08, 32'h8); wr(8'h0C, 32'h4); w256 = 1'b1;
    rd(8'h04, d); chk("R6 status mirrors", d & 32'hC, 32'hC);
    gen_check("R5 R6 word 256-bit");

    // R8 write-one-to-clear
    wr(8'h14, 32'h1); rd(8'h14, d); chk("R8 clear ready keeps seed", d, 32'h2);
    wr(8'h14, 32'h2); rd(8'h14, d); chk("R8 clear seed", d, 0);

    // R9 interrupt gating
    gen_check("R5 word");
    wr(8'h10, 32'h1); idle(1); chk("R9 no global", {31'h0, irq}, 0);
    wr(8'h10, 32'h8000_0001); idle(1); chk("R9 enabled", {31'h0, irq}, 1);
    wr(8'h10, 32'h8000_0002); idle(1); chk("R9 other cause masked", {31'h0, irq}, 0);
    wr(8'h14, 32'h13); wr(8'h10, 32'h0);

    // R7 command during busy is dropped
    seed_in = 32'h0BAD_F00D;
    wr(8'h00, 32'd2); wr(8'h00, 32'd1); idle(40);
    m = 32'h0BAD_F00D;
    rd(8'h14, d); chk("R7 gen dropped while seeding", d, 32'h2);
    gen_check("R7 result follows seed");
    wr(8'h14, 32'h13);

    // R10 lockup via zero seed
    reseed(32'h0);
    rd(8'h14, d); chk("R10 lockup cause", d & 32'h10, 32'h10);
    gen_check("R10 result from fix constant");
    wr(8'h14, 32'h13);

    // constrained random mix
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r; r = $urandom;
      if (r[0]) begin
        w256 = r[1];
        wr(8'h08, {28'h0, r[1], 3'h0});
      end
      if (r[3:2] == 2'b00) reseed($urandom);
      gen_check("R5 R6 random word");
    end
    wr(8'h14, 32'h13);

    // R11 auto reseed by request count
    seed_in = 32'hC0FF_EE11;
    wr(8'h60, 32'd2);
    gen_check("R11 gen 1");
    rd(8'h14, d); chk("R11 no reseed after 1", d & 32'h2, 0);
    gen_check("R11 gen 2");
    idle(40);
    rd(8'h14, d); chk("R11 reseed after 2", d & 32'h2, 32'h2);
    m = 32'hC0FF_EE11;
    gen_check("R11 result from new seed");
    wr(8'h60, 32'd0); wr(8'h14, 32'h13);

    // R12 auto reseed by age
    seed_in = 32'h5EED_0042;
    wr(8'h64, 32'd100); idle(50);
    rd(8'h04, d); chk("R12 no early reseed", {31'h0, d[31]}, 0);
    idle(70); wr(8'h64, 32'd0); idle(40);
    rd(8'h14, d); chk("R12 age reseed", d & 32'h2, 32'h2);
    m = 32'h5EED_0042;
    gen_check("R12 result from age seed");
    wr(8'h14, 32'h13); idle(300);
    rd(8'h14, d); chk("R12 disabled stays quiet", d & 32'h2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule